// File: doc/BRIEF.md
# Windowed Address Offset Register Bank

This block keeps four 32-bit offset registers that turn a bus-side address into an internal memory address. Software reaches the registers through a small read/write port. The port uses byte addresses 0x60, 0x64, 0x68 and 0x6C, which hold offset slots 0 to 3. Each register keeps an offset in its upper 18 bits. The low 14 bits always read as zero.

The bus side chooses a slot with a 2-bit select input. Each slot has its own enable bit and its own fine-granularity bit. When the chosen slot is enabled, the internal address is the bus address plus that slot's offset. When it is not enabled, the bus address passes through unchanged.

When an auto-update control input is high, slot 0 takes its offset from the address of each successful buffer allocation, and slot 1 takes its offset from the address of each receive-queue dequeue. Software then does not have to write these slots. A hardware load and a software write to the same slot in the same cycle are resolved in favour of the hardware load, and a sticky flag records that this happened.

Top module: `win_offset_bank`

## Requirements
- R1: After reset all four offset fields are zero, `rd_valid` is 0 and `wr_collision` is 0.
- R2: A write with `reg_wr` high to byte address 0x60, 0x64, 0x68 or 0x6C (slots 0, 1, 2, 3) stores `reg_wdata[31:14]` in that slot. A read with `reg_rd` high returns the slot in `rd_data` one cycle later, and `rd_valid` is high for exactly that cycle.
- R3: Bits 13:0 of every read value are zero, whatever was written to them.
- R4: A write to any other byte address changes no slot. A read of any other address returns 0, with `rd_valid` still pulsed.
- R5: When slot `win_sel` is enabled (`win_en[win_sel]`=1) and its fine bit is 1, `int_addr` = `bus_addr` + {offset, 14'b0}, modulo 2^32. This is combinational, in the same cycle.
- R6: When the fine bit `win_fine[win_sel]` is 0, offset bits 15:14 are treated as zero in the sum.
- R7: When `win_en[win_sel]`=0, `int_addr` equals `bus_addr`.
- R8: When `auto_upd` is 1, a `buf_get_ok` pulse loads slot 0 from `buf_get_addr` on the next edge. When `auto_upd` is 0, a `buf_get_ok` pulse does not change the slot.
- R9: When `auto_upd` is 1, a `rxq_deq_ok` pulse loads slot 1 from `rxq_deq_addr` on the next edge. When `auto_upd` is 0, a `rxq_deq_ok` pulse does not change the slot.
- R10: If a hardware load and a software write hit the same slot in the same cycle, the hardware value is kept and `wr_collision` goes high on the next edge. It then stays high until reset.
- R11: A hardware load keeps only bits 31:14 of the returned address, so bits 13:0 of the slot read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | One-cycle pulse, one cycle after reg_rd |
| auto_upd | input | 1 | Enables the hardware loads of slots 0 and 1 |
| buf_get_ok | input | 1 | Successful buffer-allocation strobe |
| buf_get_addr | input | 32 | Address returned by the allocation |
| rxq_deq_ok | input | 1 | Receive-queue dequeue strobe |
| rxq_deq_addr | input | 32 | Address returned by the dequeue |
| win_sel | input | 2 | Slot that feeds the adder |
| win_en | input | 4 | Per-slot windowing enable |
| win_fine | input | 4 | Per-slot use of offset bits 15:14 |
| bus_addr | input | 32 | Incoming bus address |
| int_addr | output | 32 | Translated internal address |
| wr_collision | output | 1 | Sticky flag for a hardware/software collision |

## Verification
The translated address is combinational. The bench therefore checks it a short delay after driving `bus_addr`, `win_sel`, `win_en` and `win_fine`, with no clock edge in between. A register write or a hardware load takes effect at the next rising edge. Read data and `rd_valid` come out at the rising edge after the read strobe, and the collision flag at the edge after the colliding cycle. The bench drives every strobe just after a falling edge and samples at the following falling edge, so each registered result is read exactly one edge after its cause. The bench also checks that `rd_valid` is low again one cycle after that.

// File: rtl/win_offset_bank.sv
module win_offset_bank #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int NREG = 4,
  parameter int OFS_LSB = 14,
  parameter int FINE_LSB = 16,
  parameter logic [7:0] BASE = 8'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          auto_upd,
  input  logic          buf_get_ok,
  input  logic [DW-1:0] buf_get_addr,
  input  logic          rxq_deq_ok,
  input  logic [DW-1:0] rxq_deq_addr,
  input  logic [1:0]    win_sel,
  input  logic [NREG-1:0] win_en,
  input  logic [NREG-1:0] win_fine,
  input  logic [DW-1:0] bus_addr,
  output logic [DW-1:0] int_addr,
  output logic          wr_collision
);
  localparam int OW = DW - OFS_LSB;
  localparam logic [DW-1:0] COARSE_MASK = ~((DW'(1) << FINE_LSB) - DW'(1));

  logic [OW-1:0] ofs [NREG];

  logic [AW-1:0] rel;
  logic          hit;
  logic [1:0]    idx;
  logic [NREG-1:0] hw_ld;
  logic [OW-1:0] hw_val [NREG];
  logic          collide;

  assign rel = reg_addr - BASE[AW-1:0];
  assign hit = (rel[1:0] == 2'b00) && (32'(rel[AW-1:2]) < NREG);
  assign idx = rel[3:2];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      hw_ld[i]  = 1'b0;
      hw_val[i] = '0;
    end
    hw_ld[0]  = auto_upd && buf_get_ok;
    hw_val[0] = buf_get_addr[DW-1:OFS_LSB];
    hw_ld[1]  = auto_upd && rxq_deq_ok;
    hw_val[1] = rxq_deq_addr[DW-1:OFS_LSB];
  end

  assign collide = reg_wr && hit && hw_ld[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ofs[i] <= '0;
      rd_data      <= '0;
      rd_valid     <= 1'b0;
      wr_collision <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= hit ? {ofs[idx], {OFS_LSB{1'b0}}} : '0;
      for (int i = 0; i < NREG; i++) begin
        if (hw_ld[i]) ofs[i] <= hw_val[i];
        else if (reg_wr && hit && idx == 2'(i)) ofs[i] <= reg_wdata[DW-1:OFS_LSB];
      end
      if (collide) wr_collision <= 1'b1;
    end
  end

  logic [DW-1:0] sel_ofs;
  assign sel_ofs  = {ofs[win_sel], {OFS_LSB{1'b0}}} & (win_fine[win_sel] ? {DW{1'b1}} : COARSE_MASK);
  assign int_addr = win_en[win_sel] ? bus_addr + sel_ofs : bus_addr;

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);
  assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid);
  assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[OFS_LSB-1:0] == '0);
  assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en[win_sel] |-> int_addr == bus_addr);
  assert_buf_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_upd && buf_get_ok) |=> ofs[0] == $past(buf_get_addr[DW-1:OFS_LSB]));
  assert_deq_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_upd && rxq_deq_ok) |=> ofs[1] == $past(rxq_deq_addr[DW-1:OFS_LSB]));
  assert_collision_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collision |=> wr_collision);
endmodule

// File: tb/win_offset_bank_bench.sv
module win_offset_bank_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, rd_data, buf_get_addr = 0, rxq_deq_addr = 0, bus_addr = 0, int_addr;
  logic rd_valid, auto_upd = 0, buf_get_ok = 0, rxq_deq_ok = 0, wr_collision;
  logic [1:0] win_sel = 0;
  logic [3:0] win_en = 0, win_fine = 0;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mdl [4];
  bit exp_coll = 0;

  always #5 clk = ~clk;

  win_offset_bank u_win_offset_bank (.*);

  function automatic int slot_of(logic [7:0] a);
    if (a == 8'h60) return 0;
    if (a == 8'h64) return 1;
    if (a == 8'h68) return 2;
    if (a == 8'h6C) return 3;
    return -1;
  endfunction

  function automatic logic [31:0] exp_addr(logic [31:0] b, logic [1:0] s, logic [3:0] en, logic [3:0] fn);
    logic [31:0] o;
    o = mdl[s] & (fn[s] ? 32'hFFFF_C000 : 32'hFFFF_0000);
    return en[s] ? b + o : b;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    int s;
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    s = slot_of(a);
    if (s >= 0) mdl[s] = d & 32'hFFFF_C000;
  endtask

  task automatic rd(logic [7:0] a, string req);
    int s;
    logic [31:0] e;
    s = slot_of(a);
    e = (s >= 0) ? mdl[s] : 32'h0;
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    chk(rd_valid === 1'b1, {req, " rd_valid"}, 32'(rd_valid), 1);
    chk(rd_data === e, req, rd_data, e);
  endtask

  task automatic win(logic [31:0] b, logic [1:0] s, logic [3:0] en, logic [3:0] fn, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = b; win_sel = s; win_en = en; win_fine = fn;
    #1;
    e = exp_addr(b, s, en, fn);
    chk(int_addr === e, req, int_addr, e);
  endtask

  task automatic hw(bit au, bit bg, logic [31:0] ba, bit dq, logic [31:0] da);
    @(negedge clk);
    auto_upd = au; buf_get_ok = bg; buf_get_addr = ba; rxq_deq_ok = dq; rxq_deq_addr = da;
    @(negedge clk);
    buf_get_ok = 0; rxq_deq_ok = 0;
    if (au && bg) mdl[0] = ba & 32'hFFFF_C000;
    if (au && dq) mdl[1] = da & 32'hFFFF_C000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    chk(wr_collision === 1'b0, "R1 collision", 32'(wr_collision), 0);
    for (int i = 0; i < 4; i++) rd(8'h60 + 8'(i * 4), "R1 reset value");
    @(negedge clk);
    chk(rd_valid === 1'b0, "R2 rd_valid pulse ends", 32'(rd_valid), 0);

    wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, "R3 low bits zero");
    wr(8'h64, 32'h1234_5678); rd(8'h64, "R2 slot1");
    wr(8'h68, 32'hABCD_0000); rd(8'h68, "R2 slot2");
    wr(8'h6C, 32'h8000_4000); rd(8'h6C, "R2 slot3");
    wr(8'h70, 32'h5555_5555); wr(8'h62, 32'h7777_7777); wr(8'h5C, 32'h9999_9999);
    rd(8'h70, "R4 unmapped read");
    for (int i = 0; i < 4; i++) rd(8'h60 + 8'(i * 4), "R4 unmapped write no effect");

    wr(8'h6C, 32'hFFFF_C000);
    win(32'h0000_4000, 2'd3, 4'b1000, 4'b1000, "R5 wrap modulo 2^32");
    win(32'h0000_0010, 2'd3, 4'b1000, 4'b0000, "R6 coarse drops bits 15:14");
    win(32'h0000_0010, 2'd0, 4'b1111, 4'b1111, "R5 fine sum");
    win(32'hDEAD_BEEF, 2'd2, 4'b1011, 4'b1111, "R7 passthrough");

    hw(0, 1, 32'h1111_1111, 1, 32'h2222_2222);
    rd(8'h60, "R8 no load without auto_upd");
    rd(8'h64, "R9 no load without auto_upd");
    hw(1, 1, 32'hCAFE_3FFF, 0, 0);
    rd(8'h60, "R8 buf load");
    rd(8'h60, "R11 low bits cleared");
    hw(1, 0, 0, 1, 32'hBEEF_7ABC);
    rd(8'h64, "R9 deq load");
    rd(8'h64, "R11 deq low bits cleared");

    chk(wr_collision === 1'b0, "R10 no collision yet", 32'(wr_collision), 0);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h60; reg_wdata = 32'h0F0F_0000;
    auto_upd = 1; buf_get_ok = 1; buf_get_addr = 32'h7654_C000;
    @(negedge clk);
    reg_wr = 0; buf_get_ok = 0;
    mdl[0] = 32'h7654_C000;
    chk(wr_collision === 1'b1, "R10 collision flag", 32'(wr_collision), 1);
    rd(8'h60, "R10 hardware wins");
    repeat (3) @(negedge clk);
    chk(wr_collision === 1'b1, "R10 collision sticky", 32'(wr_collision), 1);

    auto_upd = 0;
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: wr(8'h60 + 8'($urandom_range(0, 4) * 4), $urandom());
        1: rd(8'h60 + 8'($urandom_range(0, 4) * 4), "R2 random read");
        2: win($urandom(), 2'($urandom_range(0, 3)), 4'($urandom()), 4'($urandom()), "R5 random window");
        default: hw(1'($urandom()), 1'($urandom()), $urandom(), 1'($urandom()), $urandom());
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule